// File: doc/BRIEF.md
# Two-Wire Tuner Configuration Slave

This block is a two-wire (I2C-compatible) slave that holds the configuration bank of a broadband tuner: nine 8-bit registers for divider ratios, oscillator selection, charge-pump settings, filter offset and output selection. A host writes the bank with one transaction carrying a register pointer and any number of data bytes. Each data byte goes to the next register in turn. A read transaction returns one packed status byte built from the tuner's lock, tuning-range and power-on indicators.

SCL and SDA are oversampled by the block's own clock. Each line passes through a synchroniser and an edge detector, and a single sequencer acts on the detected edges and bus conditions. SDA is driven only low, through an output enable. Two strap pins set the low bits of the 7-bit device address. The upper five bits are fixed at binary 11000, so the write/read address pairs are C0/C1, C2/C3, C4/C5 and C6/C7 hex. Clock stretching, general call and 10-bit addressing are not supported.

Top module: `tuner_cfg_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0). Every register in the bank reads 0x00 except register 7, which reads 0x20. Register i sits at bits [8i+7:8i] of `reg_bank_o`.
- R2: The slave acknowledges an address byte whose upper seven bits equal {1,1,0,0,0,`addr_sel_i[1]`,`addr_sel_i[0]`}, with bit 0 selecting the direction (0 = write, 1 = read). It does this by pulling SDA low for the ninth SCL clock.
- R3: A register-address byte greater than 0x08 is not acknowledged, and the bank does not change.
- R4: In a write, the first data byte goes to the register named by the register-address byte. Each later data byte goes to the next higher register, and every stored byte is acknowledged.
- R5: Once the pointer has passed register 8, further data bytes are not acknowledged and no register changes.
- R6: The read byte carries first-loop lock in bit 7, second-loop lock in bit 6, the power-on-success flag in bit 5, the first tune over/under flag in bit 4 and the second tune over/under flag in bit 3. Bits 2 to 0 read 0. The status inputs are sampled when the read acknowledge ends, and the byte is sent MSB first.
- R7: After the eight read bits, the slave releases SDA for the master's NACK and stays released until the next START.
- R8: A START seen at any point, including in the middle of a byte, returns the slave to address reception with SDA released. A byte left unfinished is not stored.
- R9: The slave changes SDA only while SCL is low.
- R10: After an address that does not match, the slave drives nothing for the rest of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 2 | Strap pins giving device address bits 2:1 |
| lock1_i | input | 1 | First loop lock indicator |
| lock2_i | input | 1 | Second loop lock indicator |
| por_ok_i | input | 1 | Power-on reset completed |
| ovun1_i | input | 1 | First tune voltage out of range |
| ovun2_i | input | 1 | Second tune voltage out of range |
| reg_bank_o | output | 72 | Register bank contents, register i at [8i+7:8i] |

## Verification
Every result of the slave follows an SCL edge or a bus condition. The edge takes two synchroniser stages and one edge register to be seen, and the sequencer or bank then takes one more cycle to update. An acknowledge, a read bit or a stored register is therefore due about four clock cycles after the SCL fall that triggers it. The bench holds each SCL phase for ten clock cycles and samples SDA in the middle of the SCL high phase. It reads the bank only after the STOP, so every check lands well after its result is due and well before the next edge.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK
    } tcs_state_e;

    typedef struct packed {
        tcs_state_e  st;
        tcs_state_e  nxt;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic [7:0]  ptr;
        logic        oe;
    } tcs_ctx_t;

    function automatic logic [7:0] tcs_reset_value(input int idx);
        return (idx == 7) ? 8'h20 : 8'h00;
    endfunction

endpackage

// File: rtl/tcs_line_sync.sv
module tcs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            prev_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], line_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = prev_q;
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
    assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tcs_bank.sv
module tcs_bank #(
    parameter int NREG = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [7:0]        idx_i,
    input  logic [7:0]        data_i,
    output logic [NREG*8-1:0] bank_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [7:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val_q <= tcs_pkg::tcs_reset_value(g);
            else if (we_i && idx_i == 8'(g))
                val_q <= data_i;
        end
        assign bank_o[g*8 +: 8] = val_q;
    end

    // R5: no write may target a register beyond the bank
    a_r5_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(idx_i) < NREG));
endmodule

// File: rtl/tuner_cfg_slave.sv
module tuner_cfg_slave #(
    parameter int         NREG        = 9,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_PREFIX  = 5'b11000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        addr_sel_i,
    input  logic              lock1_i,
    input  logic              lock2_i,
    input  logic              por_ok_i,
    input  logic              ovun1_i,
    input  logic              ovun2_i,
    output logic [NREG*8-1:0] reg_bank_o
);
    import tcs_pkg::*;

    localparam logic [7:0] LAST_REG = 8'(NREG - 1);
    localparam logic [3:0] BYTE_END = 4'd8;

    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;

    tcs_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i),
        .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

    tcs_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i),
        .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

    logic bus_start, bus_stop;
    assign bus_start = scl_lvl & sda_fall;
    assign bus_stop  = scl_lvl & sda_rise;

    logic [7:0] status_byte;
    assign status_byte = {lock1_i, lock2_i, por_ok_i, ovun1_i, ovun2_i, 3'b000};

    tcs_ctx_t ctx_d, ctx_q;
    logic     wr_en_d;

    always_comb begin
        ctx_d   = ctx_q;
        wr_en_d = 1'b0;
        if (bus_start) begin
            ctx_d.st  = ST_DEV;
            ctx_d.cnt = '0;
            ctx_d.oe  = 1'b0;
        end else if (bus_stop) begin
            ctx_d.st = ST_IDLE;
            ctx_d.oe = 1'b0;
        end else begin
            case (ctx_q.st)
                ST_DEV, ST_REG, ST_WDAT: begin
                    if (scl_rise) begin
                        ctx_d.sh  = {ctx_q.sh[6:0], sda_lvl};
                        ctx_d.cnt = ctx_q.cnt + 4'd1;
                    end else if (scl_fall && ctx_q.cnt == BYTE_END) begin
                        ctx_d.cnt = '0;
                        ctx_d.st  = ST_IDLE;
                        if (ctx_q.st == ST_DEV) begin
                            if (ctx_q.sh[7:1] == {DEV_PREFIX, addr_sel_i}) begin
                                ctx_d.oe  = 1'b1;
                                ctx_d.st  = ST_ACK;
                                ctx_d.nxt = ctx_q.sh[0] ? ST_RDAT : ST_REG;
                            end
                        end else if (ctx_q.st == ST_REG) begin
                            if (ctx_q.sh <= LAST_REG) begin
                                ctx_d.ptr = ctx_q.sh;
                                ctx_d.oe  = 1'b1;
                                ctx_d.st  = ST_ACK;
                                ctx_d.nxt = ST_WDAT;
                            end
                        end else if (ctx_q.ptr <= LAST_REG) begin
                            wr_en_d   = 1'b1;
                            ctx_d.ptr = ctx_q.ptr + 8'd1;
                            ctx_d.oe  = 1'b1;
                            ctx_d.st  = ST_ACK;
                            ctx_d.nxt = ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        ctx_d.st  = ctx_q.nxt;
                        ctx_d.cnt = '0;
                        if (ctx_q.nxt == ST_RDAT) begin
                            ctx_d.sh = status_byte;
                            ctx_d.oe = ~status_byte[7];
                        end else begin
                            ctx_d.oe = 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_rise) begin
                        ctx_d.cnt = ctx_q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (ctx_q.cnt == BYTE_END) begin
                            ctx_d.oe = 1'b0;
                            ctx_d.st = ST_RACK;
                        end else begin
                            ctx_d.sh = {ctx_q.sh[6:0], 1'b0};
                            ctx_d.oe = ~ctx_q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) ctx_d.st = ST_IDLE;
                end
                default: ctx_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{st: ST_IDLE, nxt: ST_IDLE, cnt: '0, sh: '0, ptr: '0, oe: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    tcs_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en_d),
        .idx_i(ctx_q.ptr), .data_i(ctx_q.sh), .bank_o(reg_bank_o));

    assign sda_oe_o = ctx_q.oe;

    // R9: the SDA drive only moves while the sampled SCL is low
    a_r9_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.oe != $past(ctx_q.oe)) |-> !scl_lvl);

    // R8: a START returns the sequencer to address reception, SDA released
    a_r8_start_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (ctx_q.st == ST_DEV && !ctx_q.oe));

    // R7: an idle slave never holds SDA
    a_r7_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_IDLE) |-> !ctx_q.oe);

    // R3: the pointer never leaves the bank range plus one
    a_r3_ptr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ctx_q.ptr) <= NREG);
endmodule

// File: tb/tuner_cfg_slave_tb_top.sv
module tuner_cfg_slave_tb_top;
    localparam int NREG = 9;
    localparam int Q    = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] addr_sel = 2'b00;
    logic lock1 = 0, lock2 = 0, por_ok = 0, ovun1 = 0, ovun2 = 0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    logic [7:0] exp_bank [NREG];

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    tuner_cfg_slave #(.NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel),
        .lock1_i(lock1), .lock2_i(lock2), .por_ok_i(por_ok),
        .ovun1_i(ovun1), .ovun2_i(ovun2), .reg_bank_o(bank));

    function automatic logic [7:0] dev_byte(input logic [1:0] sel, input logic rd);
        return {5'b11000, sel, rd};
    endfunction

    function automatic logic [7:0] exp_status(input logic a, b, c, d, e);
        return {a, b, c, d, e, 3'b000};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(1);
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q);
        m_scl = 1'b0; tick(1);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(1'b1);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NREG; i++) chk(req, bank[i*8 +: 8], exp_bank[i]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rv;
        void'($urandom(32'd4711));
        for (int i = 0; i < NREG; i++) exp_bank[i] = (i == 7) ? 8'h20 : 8'h00;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        // R1 reset state
        chk("R1 sda", {7'd0, sda_oe}, 8'h00);
        check_bank("R1 bank");

        // R2 all four strap settings acknowledged, R4 single write
        for (int s = 0; s < 4; s++) begin
            addr_sel = 2'(s);
            bus_start();
            send_byte(dev_byte(2'(s), 1'b0), ack);
            chk("R2 addr ack", {7'd0, ack}, 8'h01);
            send_byte(8'(s), ack);
            send_byte(8'hA0 + 8'(s), ack);
            chk("R4 data ack", {7'd0, ack}, 8'h01);
            bus_stop();
            exp_bank[s] = 8'hA0 + 8'(s);
        end
        check_bank("R4 bank");

        // R2/R10 mismatched address: no ack, silent afterwards
        addr_sel = 2'b01;
        bus_start();
        send_byte(dev_byte(2'b10, 1'b0), ack);
        chk("R2 mismatch nack", {7'd0, ack}, 8'h00);
        send_byte(8'h01, ack);
        chk("R10 silent", {7'd0, ack}, 8'h00);
        bus_stop();
        check_bank("R10 bank");

        // R3 register address above 8
        bus_start();
        send_byte(dev_byte(2'b01, 1'b0), ack);
        send_byte(8'h0C, ack);
        chk("R3 reg nack", {7'd0, ack}, 8'h00);
        send_byte(8'h77, ack);
        bus_stop();
        check_bank("R3 bank");

        // R5 running past register 8
        bus_start();
        send_byte(dev_byte(2'b01, 1'b0), ack);
        send_byte(8'h07, ack);
        send_byte(8'h11, ack);
        chk("R5 reg7 ack", {7'd0, ack}, 8'h01);
        send_byte(8'h22, ack);
        chk("R5 reg8 ack", {7'd0, ack}, 8'h01);
        send_byte(8'h33, ack);
        chk("R5 past end nack", {7'd0, ack}, 8'h00);
        bus_stop();
        exp_bank[7] = 8'h11;
        exp_bank[8] = 8'h22;
        check_bank("R5 bank");

        // R8 repeated START in the middle of a data byte
        bus_start();
        send_byte(dev_byte(2'b01, 1'b0), ack);
        send_byte(8'h02, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_start();
        chk("R8 released", {7'd0, sda_oe}, 8'h00);
        send_byte(dev_byte(2'b01, 1'b0), ack);
        chk("R8 re-address ack", {7'd0, ack}, 8'h01);
        send_byte(8'h03, ack);
        send_byte(8'h5A, ack);
        bus_stop();
        exp_bank[3] = 8'h5A;
        check_bank("R8 bank");

        // R6/R7 directed read with alternating status pattern
        {lock1, lock2, por_ok, ovun1, ovun2} = 5'b10101;
        bus_start();
        send_byte(dev_byte(2'b01, 1'b1), ack);
        chk("R2 read addr ack", {7'd0, ack}, 8'h01);
        read_byte(rv);
        chk("R6 status", rv, exp_status(1, 0, 1, 0, 1));
        chk("R7 released", {7'd0, sda_oe}, 8'h00);
        bus_stop();

        // Random writes and reads
        for (int it = 0; it < 24; it++) begin
            int p, len;
            logic [1:0] sel;
            logic [4:0] st;
            logic [7:0] d;
            sel = 2'($urandom_range(0, 3));
            addr_sel = sel;
            p   = $urandom_range(0, NREG - 1);
            len = $urandom_range(1, 4);
            bus_start();
            send_byte(dev_byte(sel, 1'b0), ack);
            chk("R2 rand addr", {7'd0, ack}, 8'h01);
            send_byte(8'(p), ack);
            for (int k = 0; k < len; k++) begin
                d = 8'($urandom_range(0, 255));
                send_byte(d, ack);
                chk((p + k < NREG) ? "R4 rand ack" : "R5 rand nack",
                    {7'd0, ack}, (p + k < NREG) ? 8'h01 : 8'h00);
                if (p + k < NREG) exp_bank[p + k] = d;
            end
            bus_stop();
            check_bank("R4 rand bank");

            st = 5'($urandom_range(0, 31));
            {lock1, lock2, por_ok, ovun1, ovun2} = st;
            bus_start();
            send_byte(dev_byte(sel, 1'b1), ack);
            read_byte(rv);
            chk("R6 rand status", rv, exp_status(st[4], st[3], st[2], st[1], st[0]));
            chk("R7 rand release", {7'd0, sda_oe}, 8'h00);
            bus_stop();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule